// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This unit sits between a 32-bit register file and a byte-addressed little-endian data memory port. A load request carries an address, a transfer size (byte, halfword or word) and a signedness flag. The unit issues a word-aligned read. When the registered read data returns, it selects the addressed byte or halfword and widens it to 32 bits by sign or zero extension before writeback. A store request takes the low byte or halfword of the source operand, copies it into every lane of the 32-bit bus and raises byte enables only on the addressed lanes.

Register-to-register moves of a given size use the same extension path. They take the source from the low-order bits of the operand and write back in the cycle they are offered, with no memory traffic. A memory access whose address does not fit its size is never split or rotated. The unit consumes it, issues no memory request and no writeback, and pulses a misaligned-address exception that carries the faulting address.

Top module: `lsu_align`

## Requirements
- R1: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. Code 3 behaves exactly as a word in every path.
- R2: A byte load at offset k = `req_addr[1:0]` returns bits 8k+7 down to 8k of `mem_rdata` in `wb_data[7:0]`.
- R3: A halfword load returns `mem_rdata[15:0]` when `req_addr[1]` is 0 and `mem_rdata[31:16]` when it is 1.
- R4: When `req_signed` is 1, a byte result fills bits 31:8 with its bit 7 and a halfword result fills bits 31:16 with its bit 15. When `req_signed` is 0, those bits are zero.
- R5: A word load writes `mem_rdata` to `wb_data` unchanged, whatever the value of `req_signed`.
- R6: On a store, `mem_wdata` is `{4{req_wdata[7:0]}}` for a byte, `{2{req_wdata[15:0]}}` for a halfword and `req_wdata` for a word.
- R7: Store and load byte enables are 4'b0001 << offset for a byte, 4'b0011 << (2*addr[1]) for a halfword and 4'b1111 for a word.
- R8: A halfword access with addr[0]=1, or a word access with addr[1:0]!=0, is consumed (`req_ready`=1) with `mem_valid`=0 and `wb_valid`=0. In that same cycle `exc_misaligned` is 1 and `exc_addr` equals `req_addr`.
- R9: A move (`req_is_move`=1) is never checked for alignment and never drives `mem_valid`. In the cycle it is offered, `wb_valid` is 1 and `wb_data` is the R4-extended low byte, low halfword or whole word of `req_wdata`.
- R10: A memory request is accepted when `mem_valid` and `mem_ready` are both 1. After a load is accepted, `req_ready` stays 0 until `mem_rvalid` returns. The returned data is then extended with the size, signedness and offset captured at acceptance, and `wb_valid` is 1 in that cycle.
- R11: With the default setting, `mem_addr` is `req_addr` with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request consumed this cycle (when req_valid) |
| req_is_move | input | 1 | Register-to-register move |
| req_is_load | input | 1 | 1 = load, 0 = store (memory requests) |
| req_size | input | 2 | Transfer size code |
| req_signed | input | 1 | Sign-extend narrow results |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data or move source |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned read word |
| wb_valid | output | 1 | Register writeback strobe |
| wb_data | output | 32 | Extended writeback value |
| exc_misaligned | output | 1 | Misaligned-address exception pulse |
| exc_addr | output | ADDR_W | Faulting address |

## Verification
The bench loads a byte from each of the four lanes, with signed and unsigned data whose sign bit is both set and clear. A design with swapped lane order or inverted extension returns the wrong byte or wrong fill bits. Halfword and word accesses at every misaligned offset must give an exception with no memory request. A design that rotated the data or leaked `mem_valid` would produce a memory transaction. In one load, the request fields change while the load is outstanding. A design that extended with live inputs instead of the fields captured at acceptance would return the wrong value, and a design that did not stall would accept the move offered in the gap. Size code 3 and word loads with the signed flag set check that no extension is ever applied to full words.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
   localparam int DATA_W  = 32;
   localparam int LANES   = DATA_W / 8;
   localparam int OFF_W   = $clog2(LANES);

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
   import lsu_align_pkg::*;
(
   input  logic [1:0]       size,
   input  logic [OFF_W-1:0] off,
   output logic             misaligned
);
   always_comb begin
      case (size)
         SZ_BYTE: misaligned = 1'b0;
         SZ_HALF: misaligned = off[0];
         default: misaligned = |off;
      endcase
   end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_align_pkg::*;
(
   input  logic [DATA_W-1:0] src,
   input  logic [1:0]        size,
   input  logic [OFF_W-1:0]  off,
   output logic [DATA_W-1:0] lane_data,
   output logic [LANES-1:0]  lane_be
);
   always_comb begin
      case (size)
         SZ_BYTE: begin
            lane_data = {LANES{src[7:0]}};
            lane_be   = 4'b0001 << off;
         end
         SZ_HALF: begin
            lane_data = {(LANES/2){src[15:0]}};
            lane_be   = 4'b0011 << {off[1], 1'b0};
         end
         default: begin
            lane_data = src;
            lane_be   = '1;
         end
      endcase
   end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
   import lsu_align_pkg::*;
(
   input  logic [DATA_W-1:0] raw,
   input  logic [1:0]        size,
   input  logic              sgn,
   input  logic [OFF_W-1:0]  off,
   output logic [DATA_W-1:0] ext
);
   logic [DATA_W-1:0] shifted;
   assign shifted = raw >> {off, 3'b000};

   always_comb begin
      case (size)
         SZ_BYTE: ext = {{(DATA_W-8){sgn & shifted[7]}}, shifted[7:0]};
         SZ_HALF: ext = {{(DATA_W-16){sgn & shifted[15]}}, shifted[15:0]};
         default: ext = raw;
      endcase
   end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
   import lsu_align_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter bit WORD_ADDR_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_move,
   input  logic              req_is_load,
   input  logic [1:0]        req_size,
   input  logic              req_signed,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              wb_valid,
   output logic [31:0]       wb_data,
   output logic              exc_misaligned,
   output logic [ADDR_W-1:0] exc_addr
);
   generate
      if (ADDR_W < OFF_W + 1) begin : g_bad_addr_w
         $error("lsu_align: ADDR_W too small for byte offset");
      end
      if (DATA_W != 32) begin : g_bad_data_w
         $error("lsu_align: data path must be 32 bits");
      end
   endgenerate

   logic [OFF_W-1:0] req_off;
   logic             misal;
   logic             free;
   logic             mem_req;
   logic             load_acc;

   logic             pend_q;
   logic [1:0]       pend_size_q;
   logic             pend_sgn_q;
   logic [OFF_W-1:0] pend_off_q;

   logic [31:0]      ext_raw;
   logic [1:0]       ext_size;
   logic             ext_sgn;
   logic [OFF_W-1:0] ext_off;

   assign req_off = req_addr[OFF_W-1:0];

   lsu_align_check u_check (
      .size       (req_size),
      .off        (req_off),
      .misaligned (misal)
   );

   lsu_store_lanes u_lanes (
      .src       (req_wdata),
      .size      (req_size),
      .off       (req_off),
      .lane_data (mem_wdata),
      .lane_be   (mem_be)
   );

   assign free      = !pend_q;
   assign mem_req   = req_valid && free && !req_is_move;
   assign mem_valid = mem_req && !misal;
   assign mem_we    = !req_is_load;
   assign load_acc  = mem_valid && mem_ready && req_is_load;
   assign req_ready = free && (req_is_move || misal || mem_ready);

   assign exc_misaligned = mem_req && misal;
   assign exc_addr       = req_addr;

   generate
      if (WORD_ADDR_OUT) begin : g_word_addr
         assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end else begin : g_byte_addr
         assign mem_addr = req_addr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_size_q <= SZ_WORD;
         pend_sgn_q  <= 1'b0;
         pend_off_q  <= '0;
      end else if (pend_q) begin
         if (mem_rvalid) pend_q <= 1'b0;
      end else if (load_acc) begin
         pend_q      <= 1'b1;
         pend_size_q <= req_size;
         pend_sgn_q  <= req_signed;
         pend_off_q  <= req_off;
      end
   end

   assign ext_raw  = pend_q ? mem_rdata   : req_wdata;
   assign ext_size = pend_q ? pend_size_q : req_size;
   assign ext_sgn  = pend_q ? pend_sgn_q  : req_signed;
   assign ext_off  = pend_q ? pend_off_q  : '0;

   lsu_load_extend u_ext (
      .raw  (ext_raw),
      .size (ext_size),
      .sgn  (ext_sgn),
      .off  (ext_off),
      .ext  (wb_data)
   );

   assign wb_valid = (pend_q && mem_rvalid) || (req_valid && free && req_is_move);

   // Misaligned access: consumed, no memory request, no writeback.
   assert_misalign_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_misaligned |-> (!mem_valid && !wb_valid && req_ready));

   // Byte store enables exactly one lane.
   assert_byte_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_we && req_size == SZ_BYTE) |-> $countones(mem_be) == 1);

   // An accepted load blocks further requests in the next cycle.
   assert_load_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && !mem_we) |=> !req_ready);

   // Moves never reach memory.
   assert_move_no_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_move) |-> !mem_valid && !exc_misaligned);

   // Signed byte results carry bit 7 through the upper bits.
   assert_signed_byte_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && ext_size == SZ_BYTE && ext_sgn) |-> wb_data[31:8] == {24{wb_data[7]}});

   generate
      if (WORD_ADDR_OUT) begin : g_addr_chk
         assert_word_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid |-> mem_addr[OFF_W-1:0] == '0);
      end
   endgenerate
endmodule

// File: tb/lsu_align_tb.sv
`timescale 1ns/1ps
module lsu_align_tb;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_is_move = 1'b0, req_is_load = 1'b0;
   logic [1:0]    req_size = 2'd0;
   logic          req_signed = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic          mem_ready = 1'b0, mem_rvalid = 1'b0;
   logic [31:0]   mem_rdata = '0;
   logic          req_ready, mem_valid, mem_we, wb_valid, exc_misaligned;
   logic [AW-1:0] mem_addr, exc_addr;
   logic [3:0]    mem_be;
   logic [31:0]   mem_wdata, wb_data;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   lsu_align #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_is_move(req_is_move), .req_is_load(req_is_load),
      .req_size(req_size), .req_signed(req_signed),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .wb_valid(wb_valid), .wb_data(wb_data),
      .exc_misaligned(exc_misaligned), .exc_addr(exc_addr)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_ext(input logic [31:0] raw, input logic [1:0] sz,
                                           input logic s, input logic [1:0] off);
      logic [7:0]  b;
      logic [15:0] h;
      b = raw[off*8 +: 8];
      h = off[1] ? raw[31:16] : raw[15:0];
      if (sz == 2'd0) return s ? {{24{b[7]}}, b} : {24'h0, b};
      if (sz == 2'd1) return s ? {{16{h[15]}}, h} : {16'h0, h};
      return raw;
   endfunction

   function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] off);
      if (sz == 2'd0) return 4'b0001 << off;
      if (sz == 2'd1) return off[1] ? 4'b1100 : 4'b0011;
      return 4'b1111;
   endfunction

   task automatic idle();
      req_valid = 0; req_is_move = 0; mem_rvalid = 0; mem_ready = 0;
   endtask

   // Aligned load with one-cycle return (R2, R3, R4, R5, R10, R11).
   task automatic t_load(input logic [31:0] addr, input logic [1:0] sz, input logic s,
                         input logic [31:0] rdata, input string req);
      logic [31:0] exp;
      @(negedge clk);
      req_valid = 1; req_is_move = 0; req_is_load = 1; req_size = sz; req_signed = s;
      req_addr = addr; mem_ready = 1;
      #1;
      chk(mem_valid && !mem_we && req_ready, "R10 load request", {mem_valid, mem_we, req_ready}, 3'b101);
      chk(mem_addr == {addr[31:2], 2'b00}, "R11 word address", mem_addr, {addr[31:2], 2'b00});
      @(negedge clk);
      idle();
      mem_rvalid = 1; mem_rdata = rdata;
      #1;
      exp = ref_ext(rdata, sz, s, addr[1:0]);
      chk(wb_valid && wb_data == exp, req, {wb_valid, wb_data}, {1'b1, exp});
      @(negedge clk);
      idle();
   endtask

   task automatic t_store(input logic [31:0] addr, input logic [1:0] sz, input logic [31:0] d);
      logic [31:0] expd;
      @(negedge clk);
      req_valid = 1; req_is_move = 0; req_is_load = 0; req_size = sz; req_addr = addr;
      req_wdata = d; mem_ready = 1;
      #1;
      expd = (sz == 2'd0) ? {4{d[7:0]}} : (sz == 2'd1) ? {2{d[15:0]}} : d;
      chk(mem_valid && mem_we && mem_wdata == expd, "R6 store data", mem_wdata, expd);
      chk(mem_be == ref_be(sz, addr[1:0]), "R7 byte enables", mem_be, ref_be(sz, addr[1:0]));
      chk(!wb_valid, "R6 store has no writeback", wb_valid, 0);
      @(negedge clk);
      idle();
   endtask

   task automatic t_misalign(input logic [31:0] addr, input logic [1:0] sz, input logic ld);
      @(negedge clk);
      req_valid = 1; req_is_move = 0; req_is_load = ld; req_size = sz; req_addr = addr;
      mem_ready = 1;
      #1;
      chk(exc_misaligned && !mem_valid && !wb_valid && req_ready, "R8 misaligned rejected",
          {exc_misaligned, mem_valid, wb_valid, req_ready}, 4'b1001);
      chk(exc_addr == addr, "R8 faulting address", exc_addr, addr);
      @(negedge clk);
      idle();
      #1;
      chk(!exc_misaligned, "R8 pulse ends", exc_misaligned, 0);
   endtask

   task automatic t_move(input logic [31:0] src, input logic [1:0] sz, input logic s,
                         input logic [31:0] addr);
      logic [31:0] exp;
      @(negedge clk);
      req_valid = 1; req_is_move = 1; req_size = sz; req_signed = s; req_wdata = src;
      req_addr = addr; mem_ready = 0;
      #1;
      exp = ref_ext(src, sz, s, 2'b00);
      chk(wb_valid && wb_data == exp && !mem_valid && !exc_misaligned && req_ready,
          "R9 move extension", wb_data, exp);
      @(negedge clk);
      idle();
   endtask

   // Backpressure, stall while pending, captured fields (R10).
   task automatic t_handshake();
      logic [31:0] exp;
      @(negedge clk);
      req_valid = 1; req_is_move = 0; req_is_load = 1; req_size = 2'd1; req_signed = 1;
      req_addr = 32'h0000_0102; mem_ready = 0;
      #1;
      chk(mem_valid && !req_ready, "R10 waits for mem_ready", {mem_valid, req_ready}, 2'b10);
      @(negedge clk);
      mem_ready = 1;
      #1;
      chk(req_ready, "R10 accepted", req_ready, 1);
      @(negedge clk);
      req_is_move = 1; req_size = 2'd0; req_signed = 0; req_addr = 32'h0; req_wdata = 32'hFF;
      #1;
      chk(!req_ready && !wb_valid && !mem_valid, "R10 stall while pending",
          {req_ready, wb_valid, mem_valid}, 3'b000);
      @(negedge clk);
      req_valid = 0; mem_rvalid = 1; mem_rdata = 32'h8123_4567;
      #1;
      exp = 32'hFFFF_8123;
      chk(wb_valid && wb_data == exp, "R10 captured fields used", wb_data, exp);
      @(negedge clk);
      idle();
      req_is_move = 0;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(!mem_valid && !wb_valid && !exc_misaligned, "R10 reset idle",
          {mem_valid, wb_valid, exc_misaligned}, 0);
      rst_n = 1;
      // R2 and R4: every byte lane, signed and unsigned
      for (int k = 0; k < 4; k++) begin
         t_load(32'h0000_1000 + k, 2'd0, 1'b0, 32'h80F1_7F02, "R2 unsigned byte lane");
         t_load(32'h0000_1000 + k, 2'd0, 1'b1, 32'h80F1_7F02, "R4 signed byte lane");
      end
      // R3 and R4: both halves
      t_load(32'h0000_2000, 2'd1, 1'b1, 32'h7FFF_8001, "R3 signed low half");
      t_load(32'h0000_2002, 2'd1, 1'b1, 32'h7FFF_8001, "R3 signed high half");
      t_load(32'h0000_2000, 2'd1, 1'b0, 32'h1234_9ABC, "R4 unsigned low half");
      t_load(32'h0000_2002, 2'd1, 1'b0, 32'hFEDC_0001, "R4 unsigned high half");
      // R5 and R1: word and reserved code, signed flag ignored
      t_load(32'h0000_3000, 2'd2, 1'b1, 32'h8000_00FF, "R5 word load signed flag");
      t_load(32'h0000_3004, 2'd3, 1'b1, 32'hC0DE_F00D, "R1 size code 3 as word");
      // R6, R7 stores
      for (int k = 0; k < 4; k++) t_store(32'h0000_4000 + k, 2'd0, 32'hDEAD_BEA5);
      t_store(32'h0000_4000, 2'd1, 32'h1122_3344);
      t_store(32'h0000_4002, 2'd1, 32'h1122_3344);
      t_store(32'h0000_4000, 2'd2, 32'h1122_3344);
      t_store(32'h0000_4008, 2'd3, 32'hA5A5_0F0F);
      // R8 misaligned
      t_misalign(32'h0000_5001, 2'd1, 1'b1);
      t_misalign(32'h0000_5003, 2'd1, 1'b0);
      t_misalign(32'h0000_5001, 2'd2, 1'b1);
      t_misalign(32'h0000_5002, 2'd2, 1'b0);
      t_misalign(32'h0000_5003, 2'd3, 1'b1);
      // R9 moves, misaligned address ignored
      t_move(32'h1234_5680, 2'd0, 1'b1, 32'h3);
      t_move(32'h1234_5680, 2'd0, 1'b0, 32'h1);
      t_move(32'h0000_8001, 2'd1, 1'b1, 32'h1);
      t_move(32'hFFFF_7001, 2'd1, 1'b0, 32'h2);
      t_move(32'h8765_4321, 2'd2, 1'b1, 32'h3);
      // R10 handshake and capture
      t_handshake();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule